// File: doc/BRIEF.md
# PS/2 Host Receiver with Keyboard/Mouse Identification

This block is the receiving half of a PS/2 host in a chip. The attached keyboard or mouse drives both wires and generates the serial clock. Both wires are open-drain with pull-ups, so a released line reads as 1. The block resynchronizes and debounces the two lines, then takes one bit on each falling edge of the cleaned clock. Each frame has 11 bits. Every byte received goes out on a valid/ready stream together with an error flag.

Every falling-edge interval inside a frame is timed. An interval outside the allowed window marks the frame as broken. A clock that stays high too long in the middle of a frame discards the partial frame, which restores bit alignment. A small identification machine watches the clean bytes that arrive after the self-test code 0xAA and reports whether a device is present and whether it is a mouse.

The output stream works as follows. `m_valid` rises one cycle after a frame completes. The byte is taken on a cycle with both `m_valid` and `m_ready` high. A PS/2 device cannot be stalled, so a frame that completes while an earlier byte is still waiting is dropped. All timing parameters are counts of system clock cycles.

Top module: `ps2_host_rx`

## Requirements
- R1: After reset, `m_valid`, `device_present` and `device_is_mouse` are all 0.
- R2: A frame (bit 0 start = 0, bits 1..8 data with the LSB first, bit 9 parity, bit 10 stop = 1) with odd parity over data plus parity, and with falling-edge periods inside the window, appears on `m_data` with `m_valid` = 1 and `m_err` = 0.
- R3: A frame whose data plus parity bits hold an even number of ones is delivered with `m_err` = 1.
- R4: A frame with a start bit of 1 or a stop bit of 0 is delivered with `m_err` = 1.
- R5: Inside a frame, a period P system cycles between consecutive clock falls is accepted when TCK_MIN <= P <= TCK_MAX. A period outside that range sets `m_err` = 1 for that frame.
- R6: If the clock stays released for IDLE_TO cycles after a fall in the middle of a frame, the partial frame is discarded without output, and the next complete frame is received correctly.
- R7: While `m_valid` = 1 and `m_ready` = 0, `m_data` and `m_err` hold steady. A frame that completes during that time is dropped.
- R8: A clean 0xAA followed by a clean 0x00 gives `device_present` = 1 and `device_is_mouse` = 1.
- R9: A clean 0xAA followed by any other clean byte gives `device_present` = 1 and `device_is_mouse` = 0.
- R10: A clean 0xAA followed by no clean byte for ID_TO cycles gives `device_present` = 1 and `device_is_mouse` = 0.
- R11: A frame delivered with `m_err` = 1 does not change the identification state.
- R12: `device_present` stays 1 until the next clean 0xAA. That byte clears both outputs while a new decision is pending.
- R13: A clock pulse shorter than FILT_LEN system cycles has no effect on reception.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ps2_clk_i | input | 1 | PS/2 clock line as read at the pad (released = 1) |
| ps2_dat_i | input | 1 | PS/2 data line as read at the pad (released = 1) |
| m_valid | output | 1 | A received byte is waiting |
| m_ready | input | 1 | Consumer accepts the byte this cycle |
| m_data | output | 8 | Received data byte |
| m_err | output | 1 | Frame had a start, stop, parity or timing fault |
| device_present | output | 1 | Identification finished and a device is attached |
| device_is_mouse | output | 1 | Attached device identified as a mouse |

## Verification
Random bytes sent at random legal periods check that data and parity are recovered across the whole byte space. Random parity corruption in the same stream shows that the parity check reacts to the bit pattern and not to the byte value. Directed frames separate the individual fault causes: a bad start bit, a bad stop bit, periods that are too short or too long, an aborted partial frame, and a clock glitch. The identification sequences cover each decision path, including errored bytes placed where they could wrongly restart or settle the decision.

// File: rtl/ps2_rx_pkg.sv
package ps2_rx_pkg;
  localparam int unsigned FRAME_BITS = 11;
  localparam logic [7:0]  SELFTEST_OK = 8'hAA;
  localparam logic [7:0]  MOUSE_ID    = 8'h00;

  typedef enum logic [1:0] {
    ID_NONE,
    ID_WAIT,
    ID_KBD,
    ID_MOUSE
  } id_state_e;
endpackage

// File: rtl/ps2_line_filter.sv
module ps2_line_filter #(
  parameter int unsigned FILT_LEN = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  output logic line_o
);
  localparam int unsigned CW = $clog2(FILT_LEN + 1);
  localparam logic [CW-1:0] CNT_LAST = CW'(FILT_LEN - 1);

  logic          s1, s2;
  logic [CW-1:0] cnt;

  // two-flop synchronizer; released line reads as 1
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 1'b1;
      s2 <= 1'b1;
    end else begin
      s1 <= line_i;
      s2 <= s1;
    end
  end

  // output follows only after FILT_LEN equal differing samples
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      line_o <= 1'b1;
    end else if (s2 == line_o) begin
      cnt <= '0;
    end else if (cnt == CNT_LAST) begin
      cnt    <= '0;
      line_o <= s2;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/ps2_frame_rx.sv
module ps2_frame_rx #(
  parameter int unsigned TCK_MIN = 3000,
  parameter int unsigned TCK_MAX = 5000,
  parameter int unsigned IDLE_TO = 10000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clk_f,
  input  logic       dat_f,
  output logic       done,
  output logic [7:0] byte_o,
  output logic       err_o
);
  import ps2_rx_pkg::*;

  localparam int unsigned GW = $clog2(IDLE_TO + 1);
  localparam logic [GW-1:0] GAP_SAT = GW'(IDLE_TO);
  localparam logic [GW-1:0] GAP_LO  = GW'(TCK_MIN);
  localparam logic [GW-1:0] GAP_HI  = GW'(TCK_MAX);
  localparam logic [3:0]    IDX_END = 4'(FRAME_BITS - 1);

  logic                  clk_d;
  logic                  fall;
  logic                  active;
  logic [3:0]            idx;
  logic [FRAME_BITS-1:0] sh, nxt_sh;
  logic [GW-1:0]         gap;
  logic                  terr, gap_bad, terr_n, abort;

  assign fall    = clk_d & ~clk_f;
  assign nxt_sh  = {dat_f, sh[FRAME_BITS-1:1]};
  assign gap_bad = (gap < GAP_LO) || (gap > GAP_HI);
  assign terr_n  = terr | gap_bad;
  assign abort   = active & clk_f & (gap == GAP_SAT);

  // cycles since the last fall, counted from 1, saturating
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_d <= 1'b1;
      gap   <= GAP_SAT;
    end else begin
      clk_d <= clk_f;
      if (fall)
        gap <= GW'(1);
      else if (gap != GAP_SAT)
        gap <= gap + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      idx    <= '0;
      sh     <= '0;
      terr   <= 1'b0;
      done   <= 1'b0;
      byte_o <= '0;
      err_o  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (fall) begin
        sh <= nxt_sh;
        if (!active) begin
          active <= 1'b1;
          idx    <= 4'd1;
          terr   <= 1'b0;
        end else if (idx == IDX_END) begin
          active <= 1'b0;
          done   <= 1'b1;
          byte_o <= nxt_sh[8:1];
          err_o  <= terr_n | nxt_sh[0] | ~nxt_sh[10] | ~(^nxt_sh[9:1]);
        end else begin
          idx  <= idx + 1'b1;
          terr <= terr_n;
        end
      end else if (abort) begin
        active <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/ps2_dev_ident.sv
module ps2_dev_ident #(
  parameter int unsigned ID_TO = 2000000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       done,
  input  logic [7:0] byte_i,
  input  logic       err_i,
  output logic       present,
  output logic       is_mouse
);
  import ps2_rx_pkg::*;

  localparam int unsigned TW = $clog2(ID_TO + 1);
  localparam logic [TW-1:0] T_LAST = TW'(ID_TO - 1);

  id_state_e     st;
  logic [TW-1:0] tmr;
  logic          clean;

  assign clean    = done & ~err_i;
  assign present  = (st == ID_KBD) || (st == ID_MOUSE);
  assign is_mouse = (st == ID_MOUSE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= ID_NONE;
      tmr <= '0;
    end else if (clean && byte_i == SELFTEST_OK) begin
      st  <= ID_WAIT;
      tmr <= '0;
    end else if (st == ID_WAIT) begin
      if (clean)
        st <= (byte_i == MOUSE_ID) ? ID_MOUSE : ID_KBD;
      else if (!done) begin
        if (tmr == T_LAST)
          st <= ID_KBD;
        else
          tmr <= tmr + 1'b1;
      end
    end
  end
endmodule

// File: rtl/ps2_host_rx.sv
module ps2_host_rx #(
  parameter int unsigned FILT_LEN = 8,
  parameter int unsigned TCK_MIN  = 3000,
  parameter int unsigned TCK_MAX  = 5000,
  parameter int unsigned IDLE_TO  = 10000,
  parameter int unsigned ID_TO    = 2000000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ps2_clk_i,
  input  logic       ps2_dat_i,
  output logic       m_valid,
  input  logic       m_ready,
  output logic [7:0] m_data,
  output logic       m_err,
  output logic       device_present,
  output logic       device_is_mouse
);
  localparam int unsigned NLINES = 2;

  logic [NLINES-1:0] raw, filt;
  logic              fr_done, fr_err;
  logic [7:0]        fr_byte;

  assign raw = {ps2_dat_i, ps2_clk_i};

  for (genvar g = 0; g < NLINES; g++) begin : g_line
    ps2_line_filter #(.FILT_LEN(FILT_LEN)) u_filt (
      .clk    (clk),
      .rst_n  (rst_n),
      .line_i (raw[g]),
      .line_o (filt[g])
    );
  end

  ps2_frame_rx #(
    .TCK_MIN (TCK_MIN),
    .TCK_MAX (TCK_MAX),
    .IDLE_TO (IDLE_TO)
  ) u_frame (
    .clk    (clk),
    .rst_n  (rst_n),
    .clk_f  (filt[0]),
    .dat_f  (filt[1]),
    .done   (fr_done),
    .byte_o (fr_byte),
    .err_o  (fr_err)
  );

  ps2_dev_ident #(.ID_TO(ID_TO)) u_ident (
    .clk      (clk),
    .rst_n    (rst_n),
    .done     (fr_done),
    .byte_i   (fr_byte),
    .err_i    (fr_err),
    .present  (device_present),
    .is_mouse (device_is_mouse)
  );

  // single output slot; a frame arriving while the slot is held is dropped
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_valid <= 1'b0;
      m_data  <= '0;
      m_err   <= 1'b0;
    end else if (fr_done && (!m_valid || m_ready)) begin
      m_valid <= 1'b1;
      m_data  <= fr_byte;
      m_err   <= fr_err;
    end else if (m_ready) begin
      m_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/ps2_host_rx_chk.sv
module ps2_host_rx_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       m_valid,
  input logic       m_ready,
  input logic [7:0] m_data,
  input logic       m_err,
  input logic       device_present,
  input logic       device_is_mouse,
  input logic       fr_done,
  input logic [7:0] fr_byte,
  input logic       fr_err
);
  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!m_valid && !device_present && !device_is_mouse)); // R1

  AST_VALID_FROM_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(m_valid) |-> $past(fr_done)); // R2

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_data) && $stable(m_err))); // R7

  AST_MOUSE_PRESENT: assert property (@(posedge clk) disable iff (!rst_n)
    device_is_mouse |-> device_present); // R8

  AST_ERR_NO_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (fr_done && fr_err) |=> ($stable(device_present) && $stable(device_is_mouse))); // R11

  AST_PRESENT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(device_present) |-> $past(fr_done && !fr_err && fr_byte == 8'hAA)); // R12
endmodule

bind ps2_host_rx ps2_host_rx_chk u_chk (.*);

// File: tb/sim_ps2_host_rx.sv
`timescale 1ns/1ps
module sim_ps2_host_rx;
  localparam int FILT = 3;
  localparam int TMIN = 24;
  localparam int TMAX = 56;
  localparam int ITO  = 160;
  localparam int IDTO = 4000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ps2c = 1'b1;
  logic       ps2d = 1'b1;
  logic       m_ready = 1'b0;
  logic       m_valid, m_err, device_present, device_is_mouse;
  logic [7:0] m_data;
  int         checks = 0;
  int         errors = 0;
  bit         finished = 1'b0;

  always #2.5 clk = ~clk;

  ps2_host_rx #(
    .FILT_LEN(FILT), .TCK_MIN(TMIN), .TCK_MAX(TMAX), .IDLE_TO(ITO), .ID_TO(IDTO)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .ps2_clk_i(ps2c), .ps2_dat_i(ps2d),
    .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data), .m_err(m_err),
    .device_present(device_present), .device_is_mouse(device_is_mouse)
  );

  function automatic bit exp_err(input logic [7:0] b, input bit bpar, input bit bst,
                                 input bit bsp, input int per);
    return bpar | bst | bsp | (per < TMIN) | (per > TMAX);
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(input logic v, input int per, input bit glitch);
    ps2d = v;
    wait_cyc(per / 4);
    ps2c = 1'b0;
    wait_cyc(per / 2);
    ps2c = 1'b1;
    if (glitch) begin
      wait_cyc(1);
      ps2c = 1'b0;
      wait_cyc(1);
      ps2c = 1'b1;
      wait_cyc(per - per / 4 - per / 2 - 2);
    end else begin
      wait_cyc(per - per / 4 - per / 2);
    end
  endtask

  task automatic send_frame(input logic [7:0] b, input bit bpar, input bit bst,
                            input bit bsp, input int per, input bit glitch);
    logic [10:0] f;
    f = {~bsp, (~^b) ^ bpar, b, bst};
    for (int i = 0; i < 11; i++) send_bit(f[i], per, glitch && (i == 5));
    ps2d = 1'b1;
    wait_cyc(60);
  endtask

  task automatic send_partial(input int n);
    for (int i = 0; i < n; i++) send_bit(1'b0, 40, 1'b0);
    ps2d = 1'b1;
    wait_cyc(3 * ITO);
  endtask

  task automatic expect_out(input logic [7:0] b, input bit e, input string req);
    check(m_valid == 1'b1, req, "m_valid", m_valid, 1);
    check(m_data == b, req, "m_data", m_data, b);
    check(m_err == e, req, "m_err", m_err, e);
    m_ready = 1'b1;
    wait_cyc(1);
    m_ready = 1'b0;
    wait_cyc(1);
  endtask

  task automatic expect_id(input bit p, input bit m, input string req);
    check(device_present == p, req, "device_present", device_present, p);
    check(device_is_mouse == m, req, "device_is_mouse", device_is_mouse, m);
  endtask

  task automatic summary;
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
    summary();
  end

  initial begin
    void'($urandom(32'd4711));
    wait_cyc(5);
    // R1: reset state
    check(m_valid == 1'b0, "R1", "m_valid", m_valid, 0);
    expect_id(1'b0, 1'b0, "R1");
    rst_n = 1'b1;
    wait_cyc(5);
    check(m_valid == 1'b0, "R1", "m_valid after release", m_valid, 0);

    // R2/R3: random bytes, random legal periods, random parity faults
    for (int k = 0; k < 24; k++) begin
      logic [7:0] b;
      bit bp;
      int per;
      b   = 8'($urandom);
      bp  = ($urandom % 4) == 0;
      per = 28 + 4 * int'($urandom % 7);
      send_frame(b, bp, 1'b0, 1'b0, per, 1'b0);
      expect_out(b, exp_err(b, bp, 1'b0, 1'b0, per), bp ? "R3" : "R2");
    end
    send_frame(8'h00, 1'b0, 1'b0, 1'b0, TMIN, 1'b0);
    expect_out(8'h00, 1'b0, "R5");
    send_frame(8'hFF, 1'b0, 1'b0, 1'b0, TMAX, 1'b0);
    expect_out(8'hFF, 1'b0, "R5");

    // R4: start / stop faults
    send_frame(8'h5A, 1'b0, 1'b1, 1'b0, 40, 1'b0);
    expect_out(8'h5A, 1'b1, "R4");
    send_frame(8'hA5, 1'b0, 1'b0, 1'b1, 40, 1'b0);
    expect_out(8'hA5, 1'b1, "R4");

    // R5: period outside window
    send_frame(8'h3C, 1'b0, 1'b0, 1'b0, 16, 1'b0);
    expect_out(8'h3C, exp_err(8'h3C, 1'b0, 1'b0, 1'b0, 16), "R5");
    send_frame(8'hC3, 1'b0, 1'b0, 1'b0, 80, 1'b0);
    expect_out(8'hC3, exp_err(8'hC3, 1'b0, 1'b0, 1'b0, 80), "R5");

    // R6: partial frame discarded, then realigned
    send_partial(5);
    check(m_valid == 1'b0, "R6", "m_valid after abort", m_valid, 0);
    send_frame(8'h81, 1'b0, 1'b0, 1'b0, 40, 1'b0);
    expect_out(8'h81, 1'b0, "R6");

    // R13: short glitch on clock ignored
    send_frame(8'h6E, 1'b0, 1'b0, 1'b0, 40, 1'b1);
    expect_out(8'h6E, 1'b0, "R13");

    // R7: hold and drop under back-pressure
    send_frame(8'h12, 1'b0, 1'b0, 1'b0, 40, 1'b0);
    send_frame(8'h34, 1'b0, 1'b0, 1'b0, 40, 1'b0);
    expect_out(8'h12, 1'b0, "R7");
    check(m_valid == 1'b0, "R7", "m_valid after drop", m_valid, 0);

    // identification
    send_frame(8'hAA, 1'b0, 1'b0, 1'b0, 40, 1'b0);
    expect_out(8'hAA, 1'b0, "R12");
    expect_id(1'b0, 1'b0, "R12");
    send_frame(8'h00, 1'b0, 1'b0, 1'b0, 40, 1'b0);
    expect_out(8'h00, 1'b0, "R8");
    expect_id(1'b1, 1'b1, "R8");
    send_frame(8'hAA, 1'b1, 1'b0, 1'b0, 40, 1'b0);
    expect_out(8'hAA, 1'b1, "R11");
    expect_id(1'b1, 1'b1, "R11");
    send_frame(8'hAA, 1'b0, 1'b0, 1'b0, 40, 1'b0);
    expect_out(8'hAA, 1'b0, "R12");
    expect_id(1'b0, 1'b0, "R12");
    send_frame(8'h1C, 1'b0, 1'b0, 1'b0, 40, 1'b0);
    expect_out(8'h1C, 1'b0, "R9");
    expect_id(1'b1, 1'b0, "R9");
    send_frame(8'h00, 1'b0, 1'b0, 1'b0, 40, 1'b0);
    expect_out(8'h00, 1'b0, "R12");
    expect_id(1'b1, 1'b0, "R12");
    send_frame(8'hAA, 1'b0, 1'b0, 1'b0, 40, 1'b0);
    expect_out(8'hAA, 1'b0, "R11");
    send_frame(8'h00, 1'b1, 1'b0, 1'b0, 40, 1'b0);
    expect_out(8'h00, 1'b1, "R11");
    expect_id(1'b0, 1'b0, "R11");
    send_frame(8'h00, 1'b0, 1'b0, 1'b0, 40, 1'b0);
    expect_out(8'h00, 1'b0, "R8");
    expect_id(1'b1, 1'b1, "R8");
    send_frame(8'hAA, 1'b0, 1'b0, 1'b0, 40, 1'b0);
    expect_out(8'hAA, 1'b0, "R10");
    wait_cyc(IDTO / 2);
    expect_id(1'b0, 1'b0, "R10");
    wait_cyc(IDTO);
    expect_id(1'b1, 1'b0, "R10");

    summary();
  end
endmodule